// File: doc/BRIEF.md
# FM0 Line Encoder with Split-Edge Output Stage

This block turns a stream of data bits, one per clock cycle, into a bi-phase space (FM0) waveform on a single serial line. The clock runs at the symbol rate. Every symbol begins with a change of line level. A zero symbol adds a second change halfway through the period, and a one symbol holds its level for the whole period.

The half-period change needs no doubled clock. The output comes from a pseudo dual-edge storage cell: one register updates on the rising edge and one on the falling edge, and the line is the XOR of the two. Each register loads a value that, XORed with its partner, gives the level wanted after its edge. The encoder samples the data bit on the rising edge and holds it, so the falling-edge decision uses the symbol that the rising edge opened. A low-active asynchronous reset drives the line to 0 and a low-active asynchronous set drives it to 1. The output forcing is applied directly at the output. Either control can be removed with a parameter, and reset takes priority over set.

Top module: `fm0_line_encoder`

## Requirements
- R1: At every rising clock edge after reset or set is released, the line level inverts, whatever the data bit.
- R2: When the bit sampled at a rising edge is 0, the line inverts again at the following falling edge, giving two transitions in that symbol period.
- R3: When the bit sampled at a rising edge is 1, the line keeps its level through the following falling edge, giving one transition in that symbol period.
- R4: The symbol bit is taken only at the rising edge. Changing `sym_i` after that edge does not alter the mid-period decision.
- R5: While `rst_n` is low, `line_o` is 0, even when `set_n` is also low.
- R6: While `set_n` is low and `rst_n` is high, `line_o` is 1.
- R7: After `rst_n` rises, `line_o` stays 0 through any falling edge until the first rising edge, which drives it to 1.
- R8: After `set_n` rises during the low clock phase, `line_o` stays 1 until the next rising edge, which drives it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, low-active, forces the line to 0 |
| set_n | input | 1 | Asynchronous set, low-active, forces the line to 1 |
| sym_i | input | 1 | Data bit for the symbol that starts at the next rising edge |
| line_o | output | 1 | FM0-encoded serial line |

## Verification
The hardest case to reach from the ports is a change of `sym_i` between the rising edge that opens a symbol and the falling edge that decides its middle. An encoder that reads the live input instead of the held bit looks correct whenever the input is stable for the whole period. The stimulus therefore inverts `sym_i` two nanoseconds after every rising edge, for every symbol of the table. Each mid-period level is then correct only if the held copy is used. The bench also releases set during the low phase, so that a falling edge passes before the first post-set rising edge.

// File: rtl/fm0_pkg.sv
package fm0_pkg;

  // Level the line must take when a new symbol period opens.
  function automatic logic level_at_start(input logic cur);
    return ~cur;
  endfunction

  // Level the line must take halfway through a period carrying sym.
  function automatic logic level_at_middle(input logic cur, input logic sym);
    return sym ? cur : ~cur;
  endfunction

  // Number of line transitions expected inside one symbol period.
  function automatic int unsigned edges_per_symbol(input logic sym);
    return sym ? 1 : 2;
  endfunction

endpackage

// File: rtl/fm0_symbol_reg.sv
module fm0_symbol_reg (
  input  logic clk,
  input  logic clr_n,
  input  logic sym_i,
  output logic sym_hold_o
);
  // Cleared to 1 so that a falling edge before the first symbol
  // asks for no mid-period change and the line idles.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sym_hold_o <= 1'b1;
    else        sym_hold_o <= sym_i;
  end
endmodule

// File: rtl/fm0_split_edge_cell.sv
module fm0_split_edge_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic pre_n,
  input  logic want_rise,
  input  logic want_fall,
  output logic q_o
);
  logic half_up;
  logic half_dn;

  // Rising-edge half: chosen so that half_up ^ half_dn equals want_rise.
  always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n)      half_up <= 1'b0;
    else if (!pre_n) half_up <= 1'b1;
    else             half_up <= want_rise ? ~half_dn : half_dn;
  end

  // Falling-edge half: chosen so that half_up ^ half_dn equals want_fall.
  always_ff @(negedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n)      half_dn <= 1'b0;
    else if (!pre_n) half_dn <= 1'b0;
    else             half_dn <= want_fall ? ~half_up : half_up;
  end

  // Forcing at the output hides any spike while the halves settle.
  always_comb begin
    if (!clr_n)      q_o = 1'b0;
    else if (!pre_n) q_o = 1'b1;
    else             q_o = half_up ^ half_dn;
  end
endmodule

// File: rtl/fm0_line_encoder.sv
module fm0_line_encoder #(
  parameter bit HAS_RESET = 1'b1,
  parameter bit HAS_SET   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_n,
  input  logic sym_i,
  output logic line_o
);
  import fm0_pkg::*;

  logic rst_gate_n;
  logic set_gate_n;
  logic sym_hold;
  logic lvl_next_start;
  logic lvl_next_mid;

  generate
    if (HAS_RESET) begin : g_rst
      assign rst_gate_n = rst_n;
    end else begin : g_no_rst
      assign rst_gate_n = 1'b1;
    end
    if (HAS_SET) begin : g_set
      assign set_gate_n = set_n;
    end else begin : g_no_set
      assign set_gate_n = 1'b1;
    end
  endgenerate

  fm0_symbol_reg u_sym (
    .clk        (clk),
    .clr_n      (rst_gate_n),
    .sym_i      (sym_i),
    .sym_hold_o (sym_hold)
  );

  assign lvl_next_start = level_at_start(line_o);
  assign lvl_next_mid   = level_at_middle(line_o, sym_hold);

  fm0_split_edge_cell u_cell (
    .clk       (clk),
    .clr_n     (rst_gate_n),
    .pre_n     (set_gate_n),
    .want_rise (lvl_next_start),
    .want_fall (lvl_next_mid),
    .q_o       (line_o)
  );
endmodule

// File: rtl/fm0_line_encoder_chk.sv
module fm0_line_encoder_chk (
  input logic clk,
  input logic rst_gate_n,
  input logic set_gate_n,
  input logic sym_i,
  input logic sym_hold,
  input logic line_o
);
  logic clr_n;
  logic seen_pos;
  logic seen_neg;
  logic lvl_at_pos;
  logic lvl_at_neg;

  assign clr_n = rst_gate_n & set_gate_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      seen_pos   <= 1'b0;
      lvl_at_pos <= 1'b0;
    end else begin
      seen_pos   <= 1'b1;
      lvl_at_pos <= line_o;
    end
  end

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      seen_neg   <= 1'b0;
      lvl_at_neg <= 1'b0;
    end else begin
      seen_neg   <= seen_pos;
      lvl_at_neg <= line_o;
    end
  end

  always @(negedge clk) begin
    // R5
    if (!rst_gate_n) reset_force_chk: assert (line_o == 1'b0);
    // R6
    if (rst_gate_n && !set_gate_n) set_force_chk: assert (line_o == 1'b1);
  end

  // R1
  start_toggle_chk: assert property (@(negedge clk) disable iff (!clr_n)
    seen_pos |-> (line_o != lvl_at_pos));

  // R2
  mid_toggle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (seen_neg && !sym_hold) |-> (line_o != lvl_at_neg));

  // R3
  mid_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (seen_neg && sym_hold) |-> (line_o == lvl_at_neg));

  // R4
  sym_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
    seen_pos |-> (sym_hold == $past(sym_i)));
endmodule

bind fm0_line_encoder fm0_line_encoder_chk u_chk (
  .clk        (clk),
  .rst_gate_n (rst_gate_n),
  .set_gate_n (set_gate_n),
  .sym_i      (sym_i),
  .sym_hold   (sym_hold),
  .line_o     (line_o)
);

// File: tb/tb_fm0_line_encoder.sv
module tb_fm0_line_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_n = 1'b1;
  logic sym_i = 1'b0;
  logic line_o;

  int checks = 0;
  int errors = 0;
  logic prev_lvl;
  bit done = 1'b0;

  // Each entry: {symbol bit, expected transitions in that period}.
  localparam int NV = 12;
  localparam logic [2:0] VEC [NV] = '{
    {1'b1, 2'd1}, {1'b0, 2'd2}, {1'b0, 2'd2}, {1'b1, 2'd1},
    {1'b1, 2'd1}, {1'b1, 2'd1}, {1'b0, 2'd2}, {1'b1, 2'd1},
    {1'b0, 2'd2}, {1'b0, 2'd2}, {1'b0, 2'd2}, {1'b1, 2'd1}
  };

  fm0_line_encoder dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_n  (set_n),
    .sym_i  (sym_i),
    .line_o (line_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: line_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: transitions=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called in the low clock phase. Sends one symbol, disturbs sym_i
  // right after it is taken (R4), and checks both half periods.
  task automatic send(input logic s, input string req_start);
    logic h1, h2;
    int n;
    sym_i = s;
    @(posedge clk);
    #2 sym_i = ~s;
    #3 h1 = line_o;
    check(req_start, h1, ~prev_lvl);
    @(negedge clk);
    #5 h2 = line_o;
    check(s ? "R3/R4 hold" : "R2/R4 mid toggle", h2, s ? h1 : ~h1);
    n = int'(h1 != prev_lvl) + int'(h2 != h1);
    check_n(s ? "R3 count" : "R2 count", n, s ? 1 : 2);
    prev_lvl = h2;
  endtask

  initial begin
    // R5: reset alone, then with set also asserted
    repeat (2) @(negedge clk);
    #5 check("R5 reset", line_o, 1'b0);
    set_n = 1'b0;
    @(negedge clk);
    #5 check("R5 reset over set", line_o, 1'b0);
    set_n = 1'b1;

    // R7: release in the high phase; a falling edge passes first
    @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    #5 check("R7 idle", line_o, 1'b0);
    prev_lvl = 1'b0;
    send(VEC[0][2], "R7/R1 first start");
    check_n("R1 table count", VEC[0][1:0], 2'd1);

    for (int i = 1; i < NV; i++) begin
      send(VEC[i][2], "R1 start");
    end

    // R6: set while running, held over a full cycle
    set_n = 1'b0;
    #1 check("R6 set", line_o, 1'b1);
    @(negedge clk);
    #5 check("R6 set held", line_o, 1'b1);
    // R8: release in low phase, line waits for the rising edge
    set_n = 1'b1;
    #2 check("R8 after set", line_o, 1'b1);
    prev_lvl = 1'b1;
    send(1'b0, "R8/R1 start after set");
    send(1'b1, "R1 start");
    send(1'b0, "R1 start");

    // R5: reset while running, with set asserted too
    set_n = 1'b0;
    rst_n = 1'b0;
    #1 check("R5 reset while running", line_o, 1'b0);
    @(posedge clk);
    #5 check("R5 reset through edge", line_o, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #200000;
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule